// File: doc/BRIEF.md
# Card Hole Signature Checker

This block confirms that a punched card was sensed the same way at two read stations placed one after the other. While a card passes the first station, every row presents all column positions at once. For each column the block keeps two bits: one that goes high once any hole has been seen, and one that flips with every hole seen. Together these form the card's signature. When the same card reaches the second station, the block rebuilds the signature from the second sensing and compares it with the stored one. One cycle after the card's last row at the second station, the block reports pass or fail and, on a fail, the lowest-numbered column that disagrees.

The second station always lags the first by one card. The block therefore holds two signature banks and uses them in turn: the next card fills one bank while the bank of the previous card is waiting for its comparison. In punch-check mode, the first-station signature is built from the expected hole pattern supplied by the punch logic, not from the sensed row. The second-station sensing is then checked against what should have been punched. A card end at the second station when no signature is waiting is a sequencing error.

Top module: `hole_sig_checker`

## Requirements
- R1: After reset, `res_vld` and `seq_err` are low, and no signature is waiting for comparison.
- R2: For each column, the presence bit of a card's signature is high when at least one accepted row of that card had a 1 in that column. A column with holes at one station and none at the other fails, even when the two hole counts have the same parity.
- R3: For each column, the parity bit of the signature is the XOR of all accepted rows in that column. Equal presence with unequal parity (for example 2 holes against 3) fails. Equal presence with equal parity (for example 1 hole against 3) passes.
- R4: When the second-station signature equals the stored signature in every column, the result is a pass (`res_pass`=1, `res_col`=0).
- R5: When one or more columns differ, the result is a fail (`res_pass`=0), and `res_col` gives the lowest column index, 0-based, that differs in either bit.
- R6: `res_vld` is high for exactly one cycle, in the cycle that follows a `rd2_end` which found a waiting signature.
- R7: Up to two first-station cards can be stored before either is compared. Comparisons take the stored signatures in the order in which the cards ended at the first station.
- R8: `rd1_start` clears the bank given to the new card, so no holes left from an earlier card that used that bank reach the new card's signature.
- R9: `rd2_start` clears the second-station signature, so rows seen at the second station before it are not counted.
- R10: With `punch_mode`=1, first-station rows are taken from `exp_row`, and `row_bits` has no effect on the stored signature.
- R11: A `rd2_end` with no waiting signature pulses `seq_err` high for one cycle in the following cycle, and no result is produced.
- R12: A row is counted only in a cycle where `row_vld`=1. `row_stn`=0 selects the first station and `row_stn`=1 the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_vld | input | 1 | A row is present this cycle |
| row_stn | input | 1 | Station of the row: 0 first, 1 second |
| row_bits | input | COLS | Sensed holes of the row, one bit per column |
| exp_row | input | COLS | Expected holes of the row, used at the first station in punch-check mode |
| punch_mode | input | 1 | First-station rows come from `exp_row` |
| rd1_start | input | 1 | New card at the first station; clears its bank |
| rd1_end | input | 1 | Last row of the card at the first station has been given |
| rd2_start | input | 1 | New card at the second station; clears its signature |
| rd2_end | input | 1 | Last row of the card at the second station has been given; starts the comparison |
| res_vld | output | 1 | Result of a comparison is valid this cycle |
| res_pass | output | 1 | Card signatures matched |
| res_col | output | $clog2(COLS) | Lowest mismatching column; 0 on a pass |
| seq_err | output | 1 | A second-station card ended with no signature waiting |

## Verification
The assertions check the ordering rules on every cycle. A result appears only after a second-station card end that found a waiting signature. A sequencing error and a result are never raised together. The waiting count never exceeds two and grows by one on each accepted first-station card end. A pass always reports column 0. Whether the signatures themselves are right can only be seen in the bench scenarios. These cover the presence-only and parity-only mismatches, lowest-column selection, bank reuse after clearing, ignored rows and the punch-mode source. The behavioural model follows each of these cycle by cycle.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int unsigned NBANK = 2;

  typedef enum logic {
    STN_FIRST  = 1'b0,
    STN_SECOND = 1'b1
  } stn_e;

  // waiting-signature count after one cycle of card-end events
  function automatic logic [1:0] pend_next(input logic [1:0] cur,
                                           input logic push,
                                           input logic pop);
    logic [1:0] n;
    n = cur;
    if (push && !pop) n = cur + 2'd1;
    if (pop && !push) n = cur - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/hsc_sig_bank.sv
module hsc_sig_bank #(
  parameter int unsigned COLS = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            upd,
  input  logic [COLS-1:0] row,
  output logic [COLS-1:0] seen,
  output logic [COLS-1:0] odd
);
  // OR in the new holes
  function automatic logic [COLS-1:0] seen_step(input logic [COLS-1:0] s,
                                                input logic [COLS-1:0] r);
    return s | r;
  endfunction

  // toggle the parity of each column that has a hole
  function automatic logic [COLS-1:0] odd_step(input logic [COLS-1:0] o,
                                               input logic [COLS-1:0] r);
    return o ^ r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      seen <= '0;
      odd  <= '0;
    end else if (upd) begin
      seen <= seen_step(seen, row);
      odd  <= odd_step(odd, row);
    end
  end
endmodule

// File: rtl/hsc_bank_seq.sv
module hsc_bank_seq
  import hsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st1_end,
  input  logic       st2_end,
  output logic       wr_sel,
  output logic       rd_sel,
  output logic [1:0] pend_cnt,
  output logic       acc_ok,
  output logic       vfy_hit,
  output logic       vfy_miss
);
  assign acc_ok   = st1_end && (pend_cnt < 2'(NBANK));
  assign vfy_hit  = st2_end && (pend_cnt != 2'd0);
  assign vfy_miss = st2_end && (pend_cnt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sel   <= 1'b0;
      rd_sel   <= 1'b0;
      pend_cnt <= 2'd0;
    end else begin
      if (acc_ok)  wr_sel <= ~wr_sel;
      if (vfy_hit) rd_sel <= ~rd_sel;
      pend_cnt <= pend_next(pend_cnt, acc_ok, vfy_hit);
    end
  end
endmodule

// File: rtl/hsc_cmp.sv
module hsc_cmp #(
  parameter int unsigned COLS = 80,
  localparam int unsigned CW = $clog2(COLS)
) (
  input  logic [COLS-1:0] ref_seen,
  input  logic [COLS-1:0] ref_odd,
  input  logic [COLS-1:0] got_seen,
  input  logic [COLS-1:0] got_odd,
  output logic            any_mis,
  output logic [CW-1:0]   mis_col
);
  logic [COLS-1:0] diff;

  // index of the lowest set bit; 0 when none is set
  function automatic logic [CW-1:0] lowest_set(input logic [COLS-1:0] v);
    logic [CW-1:0] idx;
    idx = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (v[i]) idx = CW'(i);
    end
    return idx;
  endfunction

  assign diff    = (ref_seen ^ got_seen) | (ref_odd ^ got_odd);
  assign any_mis = |diff;
  assign mis_col = lowest_set(diff);
endmodule

// File: rtl/hole_sig_checker.sv
module hole_sig_checker
  import hsc_pkg::*;
#(
  parameter int unsigned COLS = 80,
  localparam int unsigned CW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_vld,
  input  logic            row_stn,
  input  logic [COLS-1:0] row_bits,
  input  logic [COLS-1:0] exp_row,
  input  logic            punch_mode,
  input  logic            rd1_start,
  input  logic            rd1_end,
  input  logic            rd2_start,
  input  logic            rd2_end,
  output logic            res_vld,
  output logic            res_pass,
  output logic [CW-1:0]   res_col,
  output logic            seq_err
);
  // named internal events, brought out for the checker
  logic       wr_sel, rd_sel;
  logic [1:0] pend_cnt;
  logic       acc_ok, vfy_hit, vfy_miss;
  logic       row1_go, row2_go;
  logic       any_mis;
  logic [CW-1:0]   mis_col;
  logic [COLS-1:0] src1;
  logic [COLS-1:0] bank_seen [NBANK];
  logic [COLS-1:0] bank_odd  [NBANK];
  logic [COLS-1:0] vf_seen, vf_odd;

  assign row1_go = row_vld && (stn_e'(row_stn) == STN_FIRST);
  assign row2_go = row_vld && (stn_e'(row_stn) == STN_SECOND);
  assign src1    = punch_mode ? exp_row : row_bits;

  hsc_bank_seq u_seq (
    .clk(clk), .rst_n(rst_n), .st1_end(rd1_end), .st2_end(rd2_end),
    .wr_sel(wr_sel), .rd_sel(rd_sel), .pend_cnt(pend_cnt),
    .acc_ok(acc_ok), .vfy_hit(vfy_hit), .vfy_miss(vfy_miss)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic mine;
    assign mine = (wr_sel == 1'(b));
    hsc_sig_bank #(.COLS(COLS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .clr(rd1_start && mine),
      .upd(row1_go && mine && !rd1_start),
      .row(src1),
      .seen(bank_seen[b]), .odd(bank_odd[b])
    );
  end

  hsc_sig_bank #(.COLS(COLS)) u_vfy (
    .clk(clk), .rst_n(rst_n),
    .clr(rd2_start),
    .upd(row2_go && !rd2_start),
    .row(row_bits),
    .seen(vf_seen), .odd(vf_odd)
  );

  hsc_cmp #(.COLS(COLS)) u_cmp (
    .ref_seen(bank_seen[rd_sel]), .ref_odd(bank_odd[rd_sel]),
    .got_seen(vf_seen), .got_odd(vf_odd),
    .any_mis(any_mis), .mis_col(mis_col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_pass <= 1'b0;
      res_col  <= '0;
      seq_err  <= 1'b0;
    end else begin
      res_vld <= vfy_hit;
      seq_err <= vfy_miss;
      if (vfy_hit) begin
        res_pass <= !any_mis;
        res_col  <= any_mis ? mis_col : '0;
      end
    end
  end
endmodule

// File: rtl/hsc_chk.sv
module hsc_chk #(
  parameter int unsigned COLS = 80,
  localparam int unsigned CW = $clog2(COLS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_vld,
  input logic          res_pass,
  input logic [CW-1:0] res_col,
  input logic          seq_err,
  input logic [1:0]    pend_cnt,
  input logic          acc_ok,
  input logic          vfy_hit,
  input logic          vfy_miss
);
  p_res_follows_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_hit |=> res_vld);

  p_res_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(vfy_hit));

  p_seq_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_miss |=> (seq_err && !res_vld));

  p_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_vld && seq_err));

  p_pass_col_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_pass) |-> (res_col == '0));

  p_col_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (int'(res_col) < int'(COLS)));

  p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= 2'd2);

  p_pend_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !vfy_hit) |=> (pend_cnt == $past(pend_cnt) + 2'd1));
endmodule

bind hole_sig_checker hsc_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_pass(res_pass),
  .res_col(res_col), .seq_err(seq_err), .pend_cnt(pend_cnt),
  .acc_ok(acc_ok), .vfy_hit(vfy_hit), .vfy_miss(vfy_miss)
);

// File: tb/sim_hole_sig_checker.sv
module sim_hole_sig_checker;
  localparam int COLS = 80;
  localparam int CW = $clog2(COLS);
  localparam int ROWS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_vld = 0, row_stn = 0, punch_mode = 0;
  logic [COLS-1:0] row_bits = '0, exp_row = '0;
  logic rd1_start = 0, rd1_end = 0, rd2_start = 0, rd2_end = 0;
  logic res_vld, res_pass, seq_err;
  logic [CW-1:0] res_col;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  hole_sig_checker #(.COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .row_vld(row_vld), .row_stn(row_stn),
    .row_bits(row_bits), .exp_row(exp_row), .punch_mode(punch_mode),
    .rd1_start(rd1_start), .rd1_end(rd1_end), .rd2_start(rd2_start),
    .rd2_end(rd2_end), .res_vld(res_vld), .res_pass(res_pass),
    .res_col(res_col), .seq_err(seq_err)
  );

  // ---------------- behavioural reference model ----------------
  logic [COLS-1:0] m1s, m1o, m2s, m2o;
  logic [2*COLS-1:0] waitq[$];
  bit e_vld = 0, e_pass = 0, e_err = 0;
  int e_col = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1s = '0; m1o = '0; m2s = '0; m2o = '0;
      waitq.delete();
      e_vld = 0; e_err = 0; e_pass = 0; e_col = 0;
    end else begin
      int sz0;
      sz0 = waitq.size();
      e_vld = 0; e_err = 0;
      if (rd2_end) begin
        if (sz0 > 0) begin
          logic [2*COLS-1:0] ent;
          bit found;
          ent = waitq.pop_front();
          found = 0; e_col = 0;
          for (int c = 0; c < COLS; c++) begin
            if (!found && (ent[c] != m2s[c] || ent[COLS+c] != m2o[c])) begin
              found = 1; e_col = c;
            end
          end
          e_vld = 1; e_pass = !found;
        end else e_err = 1;
      end
      if (rd1_end && sz0 < 2) waitq.push_back({m1o, m1s});
      if (rd1_start) begin m1s = '0; m1o = '0; end
      else if (row_vld && !row_stn) begin
        logic [COLS-1:0] s;
        s = punch_mode ? exp_row : row_bits;
        for (int c = 0; c < COLS; c++) begin
          if (s[c]) begin m1s[c] = 1'b1; m1o[c] = !m1o[c]; end
        end
      end
      if (rd2_start) begin m2s = '0; m2o = '0; end
      else if (row_vld && row_stn) begin
        for (int c = 0; c < COLS; c++) begin
          if (row_bits[c]) begin m2s[c] = 1'b1; m2o[c] = !m2o[c]; end
        end
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(res_vld), int'(e_vld), "res_vld vs model");
      check(cur_req, int'(seq_err), int'(e_err), "seq_err vs model");
      if (e_vld) begin
        check(cur_req, int'(res_pass), int'(e_pass), "res_pass vs model");
        check(cur_req, int'(res_col), e_col, "res_col vs model");
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [COLS-1:0] pat(int k, int r);
    logic [COLS-1:0] v;
    for (int c = 0; c < COLS; c++) v[c] = ((c * 7 + r * 3 + k) % 5) == 0;
    return v;
  endfunction

  task automatic row(bit stn, logic [COLS-1:0] b, logic [COLS-1:0] e);
    row_vld = 1; row_stn = stn; row_bits = b; exp_row = e;
    @(negedge clk);
    row_vld = 0; row_bits = '0; exp_row = '0;
  endtask

  task automatic ev(int which);
    case (which)
      0: rd1_start = 1;
      1: rd1_end = 1;
      2: rd2_start = 1;
      default: rd2_end = 1;
    endcase
    @(negedge clk);
    rd1_start = 0; rd1_end = 0; rd2_start = 0; rd2_end = 0;
  endtask

  task automatic card1(int k);
    ev(0);
    for (int r = 0; r < ROWS; r++) row(0, pat(k, r), pat(k + 50, r));
    ev(1);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(res_vld), 0, "res_vld in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", int'(res_vld), 0, "res_vld after reset");
    check("R1", int'(seq_err), 0, "seq_err after reset");

    // R11: end at second station with nothing waiting
    cur_req = "R11";
    ev(2);
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R11", int'(seq_err), 1, "seq_err after empty end");
    check("R11", int'(res_vld), 0, "no result on empty end");
    @(negedge clk);
    check("R11", int'(seq_err), 0, "seq_err single pulse");

    // R7: two cards stored before any comparison, verified in order
    cur_req = "R7";
    card1(1);
    card1(2);
    ev(2);
    for (int r = 0; r < ROWS; r++) row(1, pat(1, r), '0);
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R4", int'(res_vld), 1, "card A result valid");
    check("R7", int'(res_pass), 1, "card A passes from first bank");
    @(negedge clk);
    check("R6", int'(res_vld), 0, "result single cycle");

    // R5: card B with columns 9 and 30 disturbed -> lowest is 9
    cur_req = "R5";
    ev(2);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = pat(2, r);
      if (r == 0) begin b[9] = !b[9]; b[30] = !b[30]; end
      row(1, b, '0);
    end
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R5", int'(res_pass), 0, "card B fails");
    check("R5", int'(res_col), 9, "card B lowest column");

    // R2: presence-only mismatch (2 holes vs 0) in column 5; bank 0 reused (R8)
    cur_req = "R2";
    ev(0);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = '0;
      if (r == 2 || r == 3) b[5] = 1'b1;
      if (r == 1) b[11] = 1'b1;
      row(0, b, '0);
    end
    ev(1);
    ev(2);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = '0;
      if (r == 1) b[11] = 1'b1;
      row(1, b, '0);
    end
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R2", int'(res_pass), 0, "presence mismatch fails");
    check("R2", int'(res_col), 5, "presence mismatch column");

    // R3/R8/R9/R12: 1 vs 3 holes passes; junk before rd2_start and without valid
    cur_req = "R3";
    ev(0);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = '0;
      if (r == 4) b[7] = 1'b1;
      row(0, b, '0);
    end
    ev(1);
    cur_req = "R9";
    row(1, {COLS{1'b1}}, '0);
    ev(2);
    cur_req = "R12";
    row_bits = {COLS{1'b1}}; row_stn = 1; @(negedge clk); row_bits = '0;
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = '0;
      if (r == 1 || r == 5 || r == 6) b[7] = 1'b1;
      row(1, b, '0);
    end
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R3", int'(res_pass), 1, "1 vs 3 holes same signature");
    check("R8", int'(res_col), 0, "cleared bank carries no old holes");

    // R3: parity-only mismatch (2 vs 3 holes) in column 12
    cur_req = "R3";
    ev(0);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = '0;
      if (r < 2) b[12] = 1'b1;
      row(0, b, '0);
    end
    ev(1);
    ev(2);
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] b;
      b = '0;
      if (r < 3) b[12] = 1'b1;
      row(1, b, '0);
    end
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R3", int'(res_pass), 0, "parity mismatch fails");
    check("R3", int'(res_col), 12, "parity mismatch column");

    // R10: punch mode takes exp_row, row_bits garbage at first station
    cur_req = "R10";
    punch_mode = 1;
    ev(0);
    for (int r = 0; r < ROWS; r++) row(0, ~pat(5, r), pat(5, r));
    ev(1);
    punch_mode = 0;
    ev(2);
    for (int r = 0; r < ROWS; r++) row(1, pat(5, r), '0);
    rd2_end = 1; @(negedge clk); rd2_end = 0;
    check("R10", int'(res_pass), 1, "punch check against expected pattern");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule